// File: doc/BRIEF.md
# Lockdown-Aware Victim Way Selector

This block picks the way to replace when an eight-way set-associative cache allocates a line. Three kinds of lockdown filter the choice together. A global way-lock mask removes ways from every allocation. A way-allocation mask for each of eight requesting master ports limits a master to the ways dedicated to it. Per-line lock bits, read from the addressed set and presented with the request, protect individual lines. A way is eligible only when all three filters allow it.

Among the eligible ways, an invalid way is filled first, taking the lowest-numbered one. When every eligible way already holds valid data, a round-robin pointer chooses the way. If no way is eligible, the block raises a no-victim flag, and the access then proceeds without allocating. The masks are loaded through a plain write port. The decision is registered and appears one cycle after the request.

The request side carries only a valid strobe. The block accepts one request every cycle and exerts no back-pressure. The result is a single-cycle strobe that the consumer must take in the cycle it appears, because nothing holds it.

Top module: `victim_lock_sel`

## Requirements
- R1: After reset, every master's allocation mask allows all eight ways, no way is globally locked, and the round-robin pointer is at way 0.
- R2: A request with `req_valid` high in cycle n produces `vic_valid` high in cycle n+1 only. `vic_valid` is low in every cycle that does not follow a request.
- R3: A way whose bit is 1 in the global lock mask is never reported as the victim.
- R4: `req_master` (3 bits, masters 0 to 7) selects that master's allocation mask. Only ways whose bit is 1 in it may be reported as the victim, and other masters' masks have no effect on the choice.
- R5: A way whose bit is 1 in `req_line_lock` is never reported as the victim for that request.
- R6: When at least one eligible way has its `req_line_vld` bit at 0, the victim is the lowest-numbered such way.
- R7: When every eligible way is valid, the victim is the first eligible way found searching upward from the pointer and wrapping from way 7 to way 0.
- R8: After each request that yields a victim, the pointer moves to the way after the victim (way 7 wraps to 0). It is unchanged after no-victim results and in idle cycles.
- R9: When no way is eligible, `vic_none` is 1 and `vic_way` is 0 in the result cycle.
- R10: With `cfg_we` high, `cfg_global`=1 writes `cfg_data` to the global lock mask (bit n = 1 locks way n). `cfg_global`=0 writes it to the mask of master `cfg_idx` (bit n = 1 allows way n). A request presented in the write cycle uses the old masks, and requests from the next cycle on use the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mask write enable |
| cfg_global | input | 1 | 1: write the global lock mask; 0: write a master mask |
| cfg_idx | input | 3 | Master whose mask is written |
| cfg_data | input | 8 | Mask value |
| req_valid | input | 1 | Allocation request strobe |
| req_master | input | 3 | Requesting master port |
| req_line_vld | input | 8 | Valid bit of each way in the addressed set |
| req_line_lock | input | 8 | Line-lock bit of each way in the addressed set |
| vic_valid | output | 1 | Result strobe, one cycle after the request |
| vic_way | output | 3 | Chosen victim way |
| vic_none | output | 1 | No eligible way; do not allocate |

## Verification
The assertions assume that the inputs are at known values whenever `req_valid` or `cfg_we` is high. They also assume that the set state in `req_line_vld` and `req_line_lock` belongs to the same cycle as the request strobe. The bench changes every input at the falling clock edge and holds it through the next rising edge, so each request and each write is sampled in a single cycle. Requests arrive one cycle apart or back to back. A mask write and a request are placed in the same cycle only in the case that exercises the ordering rule between them.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int NWAYS    = 8;
  localparam int NMASTERS = 8;
  localparam int WAY_W    = $clog2(NWAYS);
  localparam int MST_W    = $clog2(NMASTERS);

  typedef logic [NWAYS-1:0] waymask_t;
  typedef logic [WAY_W-1:0] way_t;
  typedef logic [MST_W-1:0] mst_t;
endpackage

// File: rtl/vls_mask_bank.sv
module vls_mask_bank
  import vls_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     wr_global,
  input  mst_t     wr_idx,
  input  waymask_t wr_data,
  input  mst_t     rd_master,
  output waymask_t glock,
  output waymask_t mmask
);
  waymask_t glock_q;
  waymask_t mmask_q [NMASTERS];

  always_ff @(posedge clk) begin
    if (!rst_n) glock_q <= '0;
    else if (wr_en && wr_global) glock_q <= wr_data;
  end

  for (genvar m = 0; m < NMASTERS; m++) begin : g_mst
    always_ff @(posedge clk) begin
      if (!rst_n) mmask_q[m] <= '1;
      else if (wr_en && !wr_global && wr_idx == mst_t'(m)) mmask_q[m] <= wr_data;
    end
  end

  assign glock = glock_q;
  assign mmask = mmask_q[rd_master];

  AST_GLOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_global) |=> (glock == $past(wr_data))); // R10
  AST_MMASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_global && wr_idx == rd_master && $stable(rd_master))
    |=> (mmask == $past(wr_data))); // R10
endmodule

// File: rtl/vls_pick.sv
module vls_pick
  import vls_pkg::*;
(
  input  waymask_t elig,
  input  waymask_t line_vld,
  input  way_t     ptr,
  output logic     found,
  output way_t     way
);
  waymask_t empty_elig;
  logic     inv_found, rr_found;
  way_t     inv_way, rr_way;

  assign empty_elig = elig & ~line_vld;

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int i = 0; i < NWAYS; i++) begin
      if (!inv_found && empty_elig[i]) begin
        inv_found = 1'b1;
        inv_way   = way_t'(i);
      end
    end
  end

  always_comb begin
    rr_found = 1'b0;
    rr_way   = '0;
    for (int k = 0; k < NWAYS; k++) begin
      int j;
      j = (int'(ptr) + k) % NWAYS;
      if (!rr_found && elig[j]) begin
        rr_found = 1'b1;
        rr_way   = way_t'(j);
      end
    end
  end

  assign found = rr_found;
  assign way   = inv_found ? inv_way : rr_way;
endmodule

// File: rtl/victim_lock_sel.sv
module victim_lock_sel
  import vls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_global,
  input  logic [2:0] cfg_idx,
  input  logic [7:0] cfg_data,
  input  logic       req_valid,
  input  logic [2:0] req_master,
  input  logic [7:0] req_line_vld,
  input  logic [7:0] req_line_lock,
  output logic       vic_valid,
  output logic [2:0] vic_way,
  output logic       vic_none
);
  waymask_t glock, mmask, elig;
  logic     pick_found;
  way_t     pick_way;
  way_t     ptr_q;
  logic     vv_q, none_q;
  way_t     way_q;

  vls_mask_bank u_masks (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_global (cfg_global),
    .wr_idx    (cfg_idx),
    .wr_data   (cfg_data),
    .rd_master (req_master),
    .glock     (glock),
    .mmask     (mmask)
  );

  assign elig = ~glock & mmask & ~req_line_lock;

  vls_pick u_pick (
    .elig     (elig),
    .line_vld (req_line_vld),
    .ptr      (ptr_q),
    .found    (pick_found),
    .way      (pick_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vv_q   <= 1'b0;
      none_q <= 1'b0;
      way_q  <= '0;
      ptr_q  <= '0;
    end else begin
      vv_q <= req_valid;
      if (req_valid) begin
        none_q <= !pick_found;
        way_q  <= pick_found ? pick_way : '0;
        if (pick_found)
          ptr_q <= (pick_way == way_t'(NWAYS-1)) ? '0 : pick_way + 1'b1;
      end
    end
  end

  assign vic_valid = vv_q;
  assign vic_way   = way_q;
  assign vic_none  = none_q;

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> vic_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !vic_valid); // R2
  AST_NOT_GLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (vic_none || ((($past(glock) >> vic_way) & 8'd1) == 8'd0))); // R3
  AST_IN_MASTER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (vic_none || ((($past(mmask) >> vic_way) & 8'd1) == 8'd1))); // R4
  AST_NOT_LINE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (vic_none || ((($past(req_line_lock) >> vic_way) & 8'd1) == 8'd0))); // R5
  AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (elig & ~req_line_vld) != '0)
    |=> ((($past(req_line_vld) >> vic_way) & 8'd1) == 8'd0)); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && elig != '0) |=> $stable(ptr_q)); // R8
  AST_NONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && elig == '0) |=> (vic_none && vic_way == '0)); // R9
endmodule

// File: tb/victim_lock_sel_test.sv
module victim_lock_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_global = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [7:0] cfg_data = '0;
  logic       req_valid = 1'b0;
  logic [2:0] req_master = '0;
  logic [7:0] req_line_vld = '0, req_line_lock = '0;
  logic       vic_valid, vic_none;
  logic [2:0] vic_way;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_glock;
  logic [7:0] m_mask [8];
  int         m_ptr;

  always #2.5 clk = ~clk;

  victim_lock_sel uut (.*);

  task automatic chk(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_glock = '0;
    for (int i = 0; i < 8; i++) m_mask[i] = 8'hFF;
    m_ptr = 0;
  endtask

  // One request; checks strobe, flag and way one cycle later against the model.
  task automatic do_req(string req, int mst, logic [7:0] vld, logic [7:0] lk);
    logic [7:0] el;
    int exp_way;
    logic exp_none;
    @(negedge clk);
    req_valid = 1'b1; req_master = 3'(mst); req_line_vld = vld; req_line_lock = lk;
    el = ~m_glock & m_mask[mst] & ~lk;
    exp_none = (el == 0);
    exp_way = -1;
    for (int i = 0; i < 8; i++) if (exp_way < 0 && el[i] && !vld[i]) exp_way = i;
    for (int k = 0; k < 8; k++) if (exp_way < 0 && el[(m_ptr + k) % 8]) exp_way = (m_ptr + k) % 8;
    if (exp_none) exp_way = 0;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " strobe"}, int'(vic_valid), 1);
    chk({req, " none"}, int'(vic_none), int'(exp_none));
    chk({req, " way"}, int'(vic_way), exp_way);
    if (!exp_none) m_ptr = (exp_way + 1) % 8;
  endtask

  task automatic wr_mask(logic glob, int idx, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_global = glob; cfg_idx = 3'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (glob) m_glock = d; else m_mask[idx] = d;
  endtask

  task automatic t_reset();
    chk("R2 idle after reset", int'(vic_valid), 0);
    do_req("R1 reset pointer", 0, 8'hFF, 8'h00);
    chk("R1 way0 first", int'(vic_way), 0);
  endtask

  task automatic t_invalid_first();
    do_req("R6 lowest invalid", 2, 8'hF5, 8'h00);
    do_req("R5 line lock skips invalid", 2, 8'hF5, 8'h02);
  endtask

  task automatic t_round_robin();
    m_ptr = m_ptr; // pointer carries over from earlier requests
    do_req("R7 rr a", 1, 8'hFF, 8'h00);
    do_req("R8 rr b", 1, 8'hFF, 8'h00);
    do_req("R7 rr skip locked", 1, 8'hFF, 8'h30);
    for (int i = 0; i < 5; i++) do_req("R8 rr wrap", 3, 8'hFF, 8'h00);
  endtask

  task automatic t_global();
    wr_mask(1'b1, 0, 8'h0F);
    do_req("R3 glock rr", 0, 8'hFF, 8'h00);
    do_req("R3 glock invalid", 0, 8'hFB, 8'h00);
    for (int i = 0; i < 4; i++) do_req("R3 glock sweep", 6, 8'hFF, 8'h00);
    wr_mask(1'b1, 0, 8'h00);
  endtask

  task automatic t_master();
    wr_mask(1'b0, 5, 8'h30);
    do_req("R4 master5 a", 5, 8'hFF, 8'h00);
    do_req("R4 master5 b", 5, 8'hFF, 8'h00);
    do_req("R4 master5 invalid outside", 5, 8'hFE, 8'h00);
    do_req("R4 master0 unaffected", 0, 8'hFE, 8'h00);
  endtask

  task automatic t_none();
    int keep;
    wr_mask(1'b1, 0, 8'h10);
    keep = m_ptr;
    do_req("R9 no victim", 5, 8'h00, 8'h20);
    chk("R9 way zero", int'(vic_way), 0);
    chk("R8 ptr held", m_ptr, keep);
    wr_mask(1'b1, 0, 8'h00);
    do_req("R8 after none", 7, 8'hFF, 8'h00);
  endtask

  task automatic t_write_timing();
    logic [7:0] el;
    int exp_way;
    // Write in the same cycle as a request: the request sees old masks.
    @(negedge clk);
    cfg_we = 1'b1; cfg_global = 1'b1; cfg_data = 8'hFF;
    req_valid = 1'b1; req_master = 3'd0; req_line_vld = 8'hFF; req_line_lock = 8'h00;
    el = ~m_glock & m_mask[0];
    exp_way = -1;
    for (int k = 0; k < 8; k++) if (exp_way < 0 && el[(m_ptr + k) % 8]) exp_way = (m_ptr + k) % 8;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R10 same-cycle uses old", int'(vic_none), 0);
    chk("R10 same-cycle way", int'(vic_way), exp_way);
    m_ptr = (exp_way + 1) % 8;
    m_glock = 8'hFF;
    do_req("R10 new mask applies", 0, 8'hFF, 8'h00);
    @(negedge clk);
    chk("R2 idle no strobe", int'(vic_valid), 0);
    wr_mask(1'b1, 0, 8'h00);
    wr_mask(1'b0, 4, 8'h80);
    do_req("R10 master write", 4, 8'h7F, 8'h00);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_invalid_first();
    t_round_robin();
    t_global();
    t_master();
    t_none();
    t_write_timing();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule